// File: doc/BRIEF.md
# Expanded-Memory Page Address Translator

This block sits between the processor address path and the DRAM controller of a 286/386-class chipset that supports expanded-memory paging. It holds 64 page mapping registers, split into two banks of 32 called contexts. Each window page of 16 KB in the conventional area below 1 MB can be redirected to any 16 KB page of installed DRAM. For every presented CPU address the block returns the physical DRAM address one clock later. It also reports whether a mapping register was used, and whether the result falls inside or outside the installed memory.

The DRAM is organised as four banks. Their sizes depend on three things: the wide-bank configuration bit, the large-bank bit (which only acts on the extended chip revision 8), and the split-bank bit (which only acts on revisions 1 to 7). Addresses that no mapping register claims go through fixed relocations instead: the ROM area passes through unchanged, the top-of-16 MB ROM image aliases into the low megabyte, and memory above 1 MB is pulled down by 384 KB so it follows the 640 KB of base memory.

The block has no sequencer of its own. The only state is the register file and one output stage, both cleared by the active-low reset. The configuration inputs are expected to come from registers elsewhere in the chipset.

Top module: `ems_page_xlate`

## Requirements
- R1: During and after reset, all four outputs are zero. All 64 mapping registers are cleared, so every window address initially translates to itself.
- R2: For a mapped access, output bits [13:0] equal CPU address bits [13:0], and mapping register bits [4:0] supply output bits [18:14] before the bank base is added.
- R3: A mapping register is used only when `cfg_ems_en` is 1 and bit 9 of that register is 1. Otherwise the address takes the fixed path and `ems_hit` is 0.
- R4: The register used for window page p is number `{cfg_ctx, p}`, so bit 5 of the register number selects the context. Registers of the other context have no effect.
- R5: Window page p (0..31) starts at (p+16)·16 KB. For p of 24 or more, a further 128 KB is added, which places pages 24..31 at 0xC0000..0xDFFFF. CPU addresses at or above 1 MB are never window addresses.
- R6: The base bank shift is 21 when `cfg_wide_bank` is 1. Otherwise it is 23 when `chip_rev` is 8 and `cfg_big_bank` is 1, and 19 in all other cases. The bank is taken from register bits [8:7]. Bank bases are 0, 1<<s, 2<<s, and 2<<s plus the shift of bank 3.
- R7: If the selected bank's shift is 21 or more, register bits [6:5] are added at output bit 19. If `chip_rev` is 8 and the shift is 23, register bits [11:10] are added at output bit 21.
- R8: When `chip_rev` is between 1 and 7 and `cfg_split_bank` is 1, banks 2 and 3 use the alternate shift: 19 if `cfg_wide_bank` is 1, otherwise 21. On other revisions the split bit has no effect.
- R9: CPU addresses 0x0E0000..0x0FFFFF translate to themselves. Addresses 0xFE0000..0xFFFFFF translate to their low 20 bits. Neither sets `ems_hit`.
- R10: An unmapped address at or above 1 MB is translated to the address minus 0x60000 when `mem_kb` ≥ 1024 and `cfg_keep_high` is 0. Otherwise it passes through.
- R11: Exactly one of `dram_hit` and `out_of_range` is 1 after each translation. `out_of_range` is 1 when the translated address is at or above `mem_kb`·1024.
- R12: The outputs reflect the inputs sampled at the previous rising clock edge. A register write is seen by lookups from the following edge onward, not by a lookup in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Write strobe for a mapping register |
| map_idx | input | 6 | Mapping register number; bit 5 is the context |
| map_wdata | input | 12 | Register value: [4:0] page, [6:5] mid bits, [8:7] bank, [9] enable, [11:10] top bits |
| cfg_ems_en | input | 1 | Global paging enable |
| cfg_ctx | input | 1 | Active context |
| cfg_wide_bank | input | 1 | Selects the 21-bit bank shift |
| cfg_big_bank | input | 1 | Selects the 23-bit shift on revision 8 |
| cfg_split_bank | input | 1 | Gives banks 2 and 3 the alternate shift on revisions 1..7 |
| cfg_keep_high | input | 1 | Disables the 384 KB downward relocation above 1 MB |
| chip_rev | input | 4 | Chip revision code |
| mem_kb | input | 16 | Installed memory in KB |
| cpu_addr | input | 24 | CPU address |
| phys_addr | output | 25 | Translated DRAM address |
| ems_hit | output | 1 | A mapping register produced the address |
| dram_hit | output | 1 | Translated address lies in installed memory |
| out_of_range | output | 1 | Translated address lies beyond installed memory |

## Verification
A wrong mapping register or a wrong bank geometry shows up on the very next cycle: a lookup through the affected window produces a different `phys_addr`, and possibly a flipped `dram_hit`/`out_of_range` pair. Register corruption stays hidden until that window is addressed with paging enabled in the right context. For that reason, the stimulus mixes register writes with lookups across all pages, both contexts and every configuration combination. The bench compares all outputs with a behavioural model on every clock, so a fault is reported on the first cycle it becomes visible.

// File: rtl/ems_pkg.sv
package ems_pkg;
    localparam int PAGE_BITS      = 14;
    localparam int PAGE_FLD_W     = 5;
    localparam int MID_FLD_LSB    = 5;
    localparam int BANK_FLD_LSB   = 7;
    localparam int ENABLE_BIT     = 9;
    localparam int TOP_FLD_LSB    = 10;
    localparam int MID_DST_BIT    = 19;
    localparam int TOP_DST_BIT    = 21;
    localparam int SHIFT_NARROW   = 19;
    localparam int SHIFT_WIDE     = 21;
    localparam int SHIFT_BIG      = 23;
    localparam int REV_EXT        = 8;
    localparam int NUM_BANKS      = 4;
    localparam int WIN_FIRST_PAGE = 16;
    localparam int WIN_LOW_PAGES  = 24;
    localparam int WIN_GAP_PAGES  = 8;
    localparam int WIN_PAGES      = 32;
    localparam int HIGH_SHIFT_AMT = 32'h60000;

    typedef logic [4:0] shift_t;
endpackage

// File: rtl/ems_map_file.sv
module ems_map_file #(
    parameter int NREG = 64,
    parameter int MR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] widx,
    input  logic [MR_W-1:0]         wdata,
    input  logic [$clog2(NREG)-1:0] ridx,
    output logic [MR_W-1:0]         rdata
);
    logic [MR_W-1:0] mr_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mr_q[i] <= '0;
            end
        end else if (we) begin
            mr_q[widx] <= wdata;
        end
    end

    assign rdata = mr_q[ridx];
endmodule

// File: rtl/ems_window_decode.sv
module ems_window_decode
    import ems_pkg::*;
#(
    parameter int CPU_AW = 24
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic              in_window,
    output logic [4:0]        page_idx
);
    localparam int PN_W     = 20 - PAGE_BITS;
    localparam int LOW_END  = WIN_FIRST_PAGE + WIN_LOW_PAGES;
    localparam int HIGH_BEG = LOW_END + WIN_GAP_PAGES;
    localparam int HIGH_END = HIGH_BEG + (WIN_PAGES - WIN_LOW_PAGES);

    logic [PN_W-1:0] pn;
    logic            below_1m;

    assign pn       = cpu_addr[19:PAGE_BITS];
    assign below_1m = (cpu_addr[CPU_AW-1:20] == '0);

    always_comb begin
        in_window = 1'b0;
        page_idx  = '0;
        if (below_1m) begin
            if (int'(pn) >= WIN_FIRST_PAGE && int'(pn) < LOW_END) begin
                in_window = 1'b1;
                page_idx  = 5'(int'(pn) - WIN_FIRST_PAGE);
            end else if (int'(pn) >= HIGH_BEG && int'(pn) < HIGH_END) begin
                in_window = 1'b1;
                page_idx  = 5'(int'(pn) - WIN_FIRST_PAGE - WIN_GAP_PAGES);
            end
        end
    end
endmodule

// File: rtl/ems_bank_geom.sv
module ems_bank_geom
    import ems_pkg::*;
#(
    parameter int PA_W = 25
) (
    input  logic            cfg_wide_bank,
    input  logic            cfg_big_bank,
    input  logic            cfg_split_bank,
    input  logic [3:0]      chip_rev,
    output logic [PA_W-1:0] bank_base [NUM_BANKS],
    output logic [NUM_BANKS-1:0] bank_mid,
    output logic [NUM_BANKS-1:0] bank_top
);
    shift_t base_shift;
    shift_t alt_shift;
    logic   is_ext;
    logic   split_ok;

    assign is_ext   = (int'(chip_rev) == REV_EXT);
    assign split_ok = (chip_rev != 4'd0) && (int'(chip_rev) < REV_EXT) && cfg_split_bank;

    always_comb begin
        if (cfg_wide_bank)
            base_shift = shift_t'(SHIFT_WIDE);
        else if (is_ext && cfg_big_bank)
            base_shift = shift_t'(SHIFT_BIG);
        else
            base_shift = shift_t'(SHIFT_NARROW);

        if (split_ok)
            alt_shift = cfg_wide_bank ? shift_t'(SHIFT_NARROW) : shift_t'(SHIFT_WIDE);
        else
            alt_shift = base_shift;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        shift_t my_shift;
        assign my_shift = (b < 2) ? base_shift : alt_shift;
        assign bank_mid[b] = (int'(my_shift) >= SHIFT_WIDE);
        assign bank_top[b] = is_ext && (int'(my_shift) == SHIFT_BIG);
        if (b == 0) begin : g_zero
            assign bank_base[b] = '0;
        end else if (b < 3) begin : g_mult
            assign bank_base[b] = PA_W'(b) << base_shift;
        end else begin : g_last
            assign bank_base[b] = (PA_W'(2) << base_shift) + (PA_W'(1) << alt_shift);
        end
    end
endmodule

// File: rtl/ems_page_xlate.sv
module ems_page_xlate
    import ems_pkg::*;
#(
    parameter int CPU_AW   = 24,
    parameter int PA_W     = 25,
    parameter int MR_W     = 12,
    parameter int NREG     = 64,
    parameter int MEM_KB_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    map_we,
    input  logic [$clog2(NREG)-1:0] map_idx,
    input  logic [MR_W-1:0]         map_wdata,
    input  logic                    cfg_ems_en,
    input  logic                    cfg_ctx,
    input  logic                    cfg_wide_bank,
    input  logic                    cfg_big_bank,
    input  logic                    cfg_split_bank,
    input  logic                    cfg_keep_high,
    input  logic [3:0]              chip_rev,
    input  logic [MEM_KB_W-1:0]     mem_kb,
    input  logic [CPU_AW-1:0]       cpu_addr,
    output logic [PA_W-1:0]         phys_addr,
    output logic                    ems_hit,
    output logic                    dram_hit,
    output logic                    out_of_range
);
    localparam int IDX_W = $clog2(NREG);
    localparam int CMP_W = (PA_W > MEM_KB_W + 10 ? PA_W : MEM_KB_W + 10) + 1;

    logic             in_window;
    logic [4:0]       page_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [MR_W-1:0]  mr;
    logic [PA_W-1:0]  bank_base [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_mid;
    logic [NUM_BANKS-1:0] bank_top;

    logic [1:0]       bank;
    logic             mapped;
    logic [PA_W-1:0]  ems_pa;
    logic [PA_W-1:0]  fix_pa;
    logic [PA_W-1:0]  nxt_pa;
    logic             nxt_oor;
    logic             rom_low;
    logic             rom_high;
    logic             above_1m;

    ems_window_decode #(.CPU_AW(CPU_AW)) u_win (
        .cpu_addr  (cpu_addr),
        .in_window (in_window),
        .page_idx  (page_idx)
    );

    assign rd_idx = IDX_W'({cfg_ctx, page_idx});

    ems_map_file #(.NREG(NREG), .MR_W(MR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .widx  (map_idx),
        .wdata (map_wdata),
        .ridx  (rd_idx),
        .rdata (mr)
    );

    ems_bank_geom #(.PA_W(PA_W)) u_geom (
        .cfg_wide_bank  (cfg_wide_bank),
        .cfg_big_bank   (cfg_big_bank),
        .cfg_split_bank (cfg_split_bank),
        .chip_rev       (chip_rev),
        .bank_base      (bank_base),
        .bank_mid       (bank_mid),
        .bank_top       (bank_top)
    );

    assign bank   = mr[BANK_FLD_LSB +: 2];
    assign mapped = in_window && cfg_ems_en && mr[ENABLE_BIT];

    always_comb begin
        ems_pa = PA_W'(cpu_addr[PAGE_BITS-1:0])
               | (PA_W'(mr[PAGE_FLD_W-1:0]) << PAGE_BITS);
        if (bank_mid[bank])
            ems_pa = ems_pa | (PA_W'(mr[MID_FLD_LSB +: 2]) << MID_DST_BIT);
        if (bank_top[bank])
            ems_pa = ems_pa | (PA_W'(mr[TOP_FLD_LSB +: 2]) << TOP_DST_BIT);
        ems_pa = ems_pa + bank_base[bank];
    end

    assign above_1m = (cpu_addr[CPU_AW-1:20] != '0);
    assign rom_low  = !above_1m && (cpu_addr[19:17] == 3'b111);
    assign rom_high = (&cpu_addr[CPU_AW-1:17]);

    always_comb begin
        if (rom_low)
            fix_pa = PA_W'(cpu_addr);
        else if (rom_high)
            fix_pa = PA_W'(cpu_addr[19:0]);
        else if (above_1m && !cfg_keep_high && (int'(mem_kb) >= 1024))
            fix_pa = PA_W'(cpu_addr) - PA_W'(HIGH_SHIFT_AMT);
        else
            fix_pa = PA_W'(cpu_addr);
    end

    assign nxt_pa  = mapped ? ems_pa : fix_pa;
    assign nxt_oor = (CMP_W'(nxt_pa) >= (CMP_W'(mem_kb) << 10));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phys_addr    <= '0;
            ems_hit      <= 1'b0;
            dram_hit     <= 1'b0;
            out_of_range <= 1'b0;
        end else begin
            phys_addr    <= nxt_pa;
            ems_hit      <= mapped;
            dram_hit     <= !nxt_oor;
            out_of_range <= nxt_oor;
        end
    end
endmodule

// File: rtl/ems_page_xlate_chk.sv
module ems_page_xlate_chk #(
    parameter int CPU_AW = 24,
    parameter int PA_W   = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_ems_en,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [PA_W-1:0]   phys_addr,
    input logic              ems_hit,
    input logic              dram_hit,
    input logic              out_of_range
);
    a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones({dram_hit, out_of_range}) == 1));

    a_r9_rom_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_addr) >= CPU_AW'(32'hE0000) && $past(cpu_addr) <= CPU_AW'(32'hFFFFF))
        |-> (phys_addr == PA_W'($past(cpu_addr)) && !ems_hit));

    a_r9_high_alias: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_addr) >= CPU_AW'(32'hFE0000))
        |-> (phys_addr == PA_W'($past(cpu_addr[19:0])) && !ems_hit));

    a_r3_no_map_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_ems_en)) |-> !ems_hit);

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ems_hit) |-> (phys_addr[13:0] == $past(cpu_addr[13:0])));

    a_r5_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_addr) >= CPU_AW'(32'h100000)) |-> !ems_hit);
endmodule

bind ems_page_xlate ems_page_xlate_chk #(.CPU_AW(CPU_AW), .PA_W(PA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ems_en   (cfg_ems_en),
    .cpu_addr     (cpu_addr),
    .phys_addr    (phys_addr),
    .ems_hit      (ems_hit),
    .dram_hit     (dram_hit),
    .out_of_range (out_of_range)
);

// File: tb/ems_page_xlate_bench.sv
`timescale 1ns/1ps
module ems_page_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_we = 1'b0;
    logic [5:0]  map_idx = '0;
    logic [11:0] map_wdata = '0;
    logic        cfg_ems_en = 1'b0;
    logic        cfg_ctx = 1'b0;
    logic        cfg_wide_bank = 1'b0;
    logic        cfg_big_bank = 1'b0;
    logic        cfg_split_bank = 1'b0;
    logic        cfg_keep_high = 1'b0;
    logic [3:0]  chip_rev = '0;
    logic [15:0] mem_kb = 16'd4096;
    logic [23:0] cpu_addr = '0;
    logic [24:0] phys_addr;
    logic        ems_hit;
    logic        dram_hit;
    logic        out_of_range;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int mirror [64];

    always #5 clk = ~clk;

    ems_page_xlate u_ems_page_xlate (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_idx(map_idx),
        .map_wdata(map_wdata), .cfg_ems_en(cfg_ems_en), .cfg_ctx(cfg_ctx),
        .cfg_wide_bank(cfg_wide_bank), .cfg_big_bank(cfg_big_bank),
        .cfg_split_bank(cfg_split_bank), .cfg_keep_high(cfg_keep_high),
        .chip_rev(chip_rev), .mem_kb(mem_kb), .cpu_addr(cpu_addr),
        .phys_addr(phys_addr), .ems_hit(ems_hit), .dram_hit(dram_hit),
        .out_of_range(out_of_range)
    );

    task automatic check(input string req, input longint act, input longint exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model built from the requirements.
    function automatic void model(input longint a, output longint pa, output bit hit);
        longint pn;
        int     idx;
        hit = 0;
        pa  = a;
        if (a >= 'hE0000 && a <= 'hFFFFF) begin
            pa = a;
        end else if (a >= 'hFE0000) begin
            pa = a - 'hF00000;
        end else begin
            idx = -1;
            pn  = a / 16384;
            if (a < 'h100000) begin
                if (pn >= 16 && pn < 40) idx = int'(pn) - 16;
                else if (pn >= 48 && pn < 56) idx = int'(pn) - 24;
            end
            if (idx >= 0 && cfg_ems_en && ((mirror[(cfg_ctx ? 32 : 0) + idx] / 512) % 2 == 1)) begin
                int m, s, alt, b, sh;
                longint base;
                m   = mirror[(cfg_ctx ? 32 : 0) + idx];
                s   = cfg_wide_bank ? 21 : ((chip_rev == 8 && cfg_big_bank) ? 23 : 19);
                alt = (chip_rev >= 1 && chip_rev <= 7 && cfg_split_bank) ? (cfg_wide_bank ? 19 : 21) : s;
                b   = (m / 128) % 4;
                sh  = (b < 2) ? s : alt;
                case (b)
                    0: base = 0;
                    1: base = longint'(1) << s;
                    2: base = longint'(2) << s;
                    default: base = (longint'(2) << s) + (longint'(1) << alt);
                endcase
                pa = (a % 16384) + longint'(m % 32) * 16384;
                if (sh >= 21) pa += longint'((m / 32) % 4) * (longint'(1) << 19);
                if (chip_rev == 8 && sh == 23) pa += longint'((m / 1024) % 4) * (longint'(1) << 21);
                pa += base;
                hit = 1;
            end else if (a >= 'h100000 && mem_kb >= 1024 && !cfg_keep_high) begin
                pa = a - 'h60000;
            end
        end
    endfunction

    // One clock: drive at a falling edge, compare at the next falling edge.
    task automatic step(input string req, input longint a, input bit we = 0,
                        input int widx = 0, input int wd = 0);
        longint epa;
        bit     ehit;
        bit     eoor;
        cpu_addr  = 24'(a);
        map_we    = we;
        map_idx   = 6'(widx);
        map_wdata = 12'(wd);
        model(a, epa, ehit);
        eoor = (epa >= longint'(mem_kb) * 1024);
        if (we) mirror[widx] = wd;
        @(negedge clk);
        map_we = 1'b0;
        check(req, phys_addr, epa, "phys_addr");
        check(req, ems_hit, ehit, "ems_hit");
        check(req, out_of_range, eoor, "out_of_range");
        check(req, dram_hit, !eoor, "dram_hit");
    endtask

    task automatic wr(input int idx, input int wd);
        step("R12", 24'h000100, 1, idx, wd);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mirror[i] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1", phys_addr, 0, "phys_addr in reset");
        check("R1", {ems_hit, dram_hit, out_of_range}, 0, "flags in reset");
        rst_n = 1'b1;
        cfg_ems_en = 1'b1;
        step("R1", 24'h044123);
        step("R1", 24'h0C8000);

        // R2/R3: page 1 mapped to page 5 in bank 0
        wr(1, 'h205);
        step("R2", 24'h045ABC);
        step("R2", 24'h047FFF);
        cfg_ems_en = 1'b0;
        step("R3", 24'h045ABC);
        cfg_ems_en = 1'b1;
        wr(2, 'h007);
        step("R3", 24'h048010);

        // R12: same-cycle write and lookup sees old value
        step("R12", 24'h04C020, 1, 3, 'h209);
        step("R12", 24'h04C020);

        // R4: contexts
        wr(33, 'h21F);
        step("R4", 24'h044444);
        cfg_ctx = 1'b1;
        step("R4", 24'h044444);
        step("R4", 24'h045ABC);
        cfg_ctx = 1'b0;

        // R5: high window pages and the gap between
        wr(24, 'h203);
        wr(31, 'h21E);
        step("R5", 24'h0C0010);
        step("R5", 24'h0DFFF0);
        step("R5", 24'h0A4000);
        step("R5", 24'h144000);

        // R6/R7: bank bases and mid/top fields
        mem_kb = 16'd32768;
        wr(4, 'h2E1);
        wr(5, 'h3C2);
        wr(6, 'hFE3);
        step("R6", 24'h050000);
        step("R6", 24'h054000);
        cfg_wide_bank = 1'b1;
        step("R7", 24'h050000);
        step("R7", 24'h054000);
        step("R7", 24'h058000);
        cfg_wide_bank = 1'b0; cfg_big_bank = 1'b1;
        step("R6", 24'h058000);
        chip_rev = 4'd8;
        step("R7", 24'h050000);
        step("R7", 24'h058000);
        cfg_big_bank = 1'b0;

        // R8: split banks on revisions 1..7 only
        cfg_split_bank = 1'b1;
        step("R8", 24'h054000);
        chip_rev = 4'd2;
        step("R8", 24'h054000);
        step("R8", 24'h058000);
        cfg_wide_bank = 1'b1;
        step("R8", 24'h058000);
        chip_rev = 4'd0;
        step("R8", 24'h058000);
        cfg_wide_bank = 1'b0; cfg_split_bank = 1'b0;

        // R9: ROM pass and alias
        step("R9", 24'h0E1234);
        step("R9", 24'h0FFFFF);
        step("R9", 24'hFE0042);
        step("R9", 24'hFFFFF0);

        // R10: relocation above 1 MB
        mem_kb = 16'd4096;
        step("R10", 24'h100000);
        step("R10", 24'h23ABCD);
        cfg_keep_high = 1'b1;
        step("R10", 24'h23ABCD);
        cfg_keep_high = 1'b0;
        mem_kb = 16'd640;
        step("R10", 24'h120000);

        // R11: out of range
        mem_kb = 16'd512;
        wr(7, 'h281);
        step("R11", 24'h05C000);
        step("R11", 24'h07FFFF);
        mem_kb = 16'd1024;

        // Mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            int k;
            longint a;
            k = $urandom_range(0, 9);
            if (k == 0) begin
                cfg_ctx = 1'($urandom); cfg_ems_en = ($urandom_range(0, 3) != 0);
                cfg_wide_bank = 1'($urandom); cfg_big_bank = 1'($urandom);
                cfg_split_bank = 1'($urandom); cfg_keep_high = 1'($urandom);
                chip_rev = 4'($urandom_range(0, 9));
                mem_kb = 16'($urandom_range(256, 32768));
            end
            case ($urandom_range(0, 3))
                0: a = 'h40000 + $urandom_range(0, 'h5FFFF);
                1: a = 'hC0000 + $urandom_range(0, 'h1FFFF);
                2: a = $urandom_range(0, 'hFFFFFF);
                default: a = 'hE0000 + $urandom_range(0, 'h1FFFF);
            endcase
            if (k == 1)
                step("R6", a, 1, $urandom_range(0, 63), $urandom_range(0, 4095));
            else
                step("R7", a);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule